// File: doc/BRIEF.md
# Return-Address Guard Stack

This block keeps a small on-chip stack of return addresses that protects function returns against control-flow hijacking. A function prologue issues a push carrying the return address. The epilogue first issues a pop, which moves the top entry into an internal popped-value register and onto `data_out`. It then issues a check, which compares that popped value with the current link register. If they differ, the block raises an illegal-instruction exception.

The stack can only be written through its own push and swap commands. A swap atomically replaces the top entry with the supplied data and returns the old entry. Pushing onto a full stack raises an overflow fault. Popping or swapping on an empty stack raises an underflow fault. In both fault cases the stack is left as it was. The block acts only while `enable` is high; `enable` reflects whether return protection is on for the current privilege mode. While `enable` is low, every command is ignored and no exception is raised. The stack depth is a parameter.

Top module: `ret_guard_stack`

## Requirements
- R1: After reset the stack is empty, no popped value is held, `data_out` is 0 and all three exception outputs are low.
- R2: Commands are taken when `cmd_valid` and `enable` are both high. The `cmd` codes are 3'd1 push, 3'd2 pop, 3'd3 check and 3'd4 swap; any other code has no effect. A push of `data_in` onto a stack that is not full stores it as the new top entry.
- R3: A pop on a non-empty stack removes the top entry in last-in-first-out order. That entry appears on `data_out` and becomes the held popped value, one cycle after the command.
- R4: A check raises `exc_illegal` for exactly one cycle, one cycle after the command, when the held popped value differs from `link_reg`. On a match no exception is raised. Every check consumes the held popped value.
- R5: A check issued while no popped value is held raises `exc_illegal`. This includes a second check after a first one.
- R6: A push onto a full stack (DEPTH entries) raises `exc_overflow` for one cycle and leaves every stored entry unchanged.
- R7: A pop on an empty stack raises `exc_underflow` for one cycle and leaves `data_out` unchanged.
- R8: A swap on a non-empty stack writes `data_in` into the top entry and puts the previous top entry on `data_out` one cycle later, without changing the stack depth. A swap on an empty stack raises `exc_underflow` and changes nothing.
- R9: While `enable` is low, no command changes the stack or `data_out` and no exception is raised.
- R10: While `cmd_valid` is low, the stack and `data_out` are unchanged whatever `cmd` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Return protection active for the current privilege mode |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 3 | Command code (1 push, 2 pop, 3 check, 4 swap) |
| data_in | input | AW | Return address for push, new top value for swap |
| link_reg | input | AW | Current link register value used by check |
| data_out | output | AW | Last value popped or swapped out |
| exc_illegal | output | 1 | Illegal-instruction exception from a failed check |
| exc_overflow | output | 1 | Push onto a full stack |
| exc_underflow | output | 1 | Pop or swap on an empty stack |

## Verification
Every result is registered exactly once. `data_out` and all three exception pulses are therefore due one cycle after the clock edge that accepts a command, and each exception lasts only that one cycle. The bench drives a command on a falling edge and removes the strobe at the next falling edge, after the accepting rising edge. It samples all outputs at that point, where they must already show the new values. Because no strobe is active at the following edge, an exception that lingers for a second cycle, or that arrives one cycle late, shows up in the next sample. Ignored commands are judged by popping afterwards and comparing the data that comes back.

// File: rtl/ret_guard_pkg.sv
package ret_guard_pkg;

    typedef enum logic [2:0] {
        RG_NOP   = 3'd0,
        RG_PUSH  = 3'd1,
        RG_POP   = 3'd2,
        RG_CHECK = 3'd3,
        RG_SWAP  = 3'd4
    } rg_cmd_e;

endpackage

// File: rtl/ret_guard_mem.sv
module ret_guard_mem #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_data
);

    logic [AW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_data = slot_q[i];
            end
        end
    end

endmodule

// File: rtl/ret_guard_cmp.sv
module ret_guard_cmp #(
    parameter int AW = 32
) (
    input  logic          held_valid,
    input  logic [AW-1:0] held_val,
    input  logic [AW-1:0] link_val,
    output logic          mismatch
);

    // A missing popped value counts as a mismatch.
    always_comb begin
        mismatch = !held_valid || (held_val != link_val);
    end

endmodule

// File: rtl/ret_guard_stack.sv
module ret_guard_stack
    import ret_guard_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd,
    input  logic [AW-1:0] data_in,
    input  logic [AW-1:0] link_reg,
    output logic [AW-1:0] data_out,
    output logic          exc_illegal,
    output logic          exc_overflow,
    output logic          exc_underflow
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0] count;
        logic [AW-1:0] held;
        logic          held_valid;
        logic [AW-1:0] dout;
        logic          exc_ill;
        logic          exc_ovf;
        logic          exc_unf;
    } rg_state_t;

    rg_state_t     st_d, st_q;
    rg_cmd_e       op;
    logic          full, empty, mismatch;
    logic          wr_en;
    logic [IW-1:0] wr_idx, top_idx;
    logic [AW-1:0] wr_data, top_data;
    logic [CW-1:0] count_q;
    logic          held_valid_q;

    assign op           = rg_cmd_e'(cmd);
    assign count_q      = st_q.count;
    assign held_valid_q = st_q.held_valid;
    assign full         = (st_q.count == CW'(DEPTH));
    assign empty        = (st_q.count == '0);
    assign top_idx      = empty ? '0 : IW'(st_q.count - 1'b1);

    ret_guard_mem #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (top_idx),
        .rd_data (top_data)
    );

    ret_guard_cmp #(.AW(AW)) u_cmp (
        .held_valid (st_q.held_valid),
        .held_val   (st_q.held),
        .link_val   (link_reg),
        .mismatch   (mismatch)
    );

    always_comb begin
        st_d         = st_q;
        st_d.exc_ill = 1'b0;
        st_d.exc_ovf = 1'b0;
        st_d.exc_unf = 1'b0;
        wr_en        = 1'b0;
        wr_idx       = top_idx;
        wr_data      = data_in;
        if (enable && cmd_valid) begin
            case (op)
                RG_PUSH: begin
                    if (full) begin
                        st_d.exc_ovf = 1'b1;
                    end else begin
                        wr_en      = 1'b1;
                        wr_idx     = IW'(st_q.count);
                        st_d.count = st_q.count + 1'b1;
                    end
                end
                RG_POP: begin
                    if (empty) begin
                        st_d.exc_unf = 1'b1;
                    end else begin
                        st_d.held       = top_data;
                        st_d.held_valid = 1'b1;
                        st_d.dout       = top_data;
                        st_d.count      = st_q.count - 1'b1;
                    end
                end
                RG_CHECK: begin
                    st_d.exc_ill    = mismatch;
                    st_d.held_valid = 1'b0;
                end
                RG_SWAP: begin
                    if (empty) begin
                        st_d.exc_unf = 1'b1;
                    end else begin
                        wr_en     = 1'b1;
                        wr_idx    = top_idx;
                        st_d.dout = top_data;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out      = st_q.dout;
    assign exc_illegal   = st_q.exc_ill;
    assign exc_overflow  = st_q.exc_ovf;
    assign exc_underflow = st_q.exc_unf;

endmodule

// File: rtl/ret_guard_chk.sv
module ret_guard_chk
    import ret_guard_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd,
    input  logic          exc_illegal,
    input  logic          exc_overflow,
    input  logic          exc_underflow,
    input  logic [CW-1:0] count_q,
    input  logic          held_valid_q
);

    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !(exc_illegal || exc_overflow || exc_underflow));

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        exc_overflow |-> (count_q == CW'(DEPTH)) && $stable(count_q));

    a_r7_underflow_empty: assert property (@(posedge clk) disable iff (!rst_n)
        exc_underflow |-> (count_q == '0));

    a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cmd_valid && cmd == RG_PUSH && count_q != CW'(DEPTH))
        |=> count_q == $past(count_q) + 1'b1);

    a_r5_check_unheld: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cmd_valid && cmd == RG_CHECK && !held_valid_q)
        |=> exc_illegal && !held_valid_q);

    a_r4_single_exc: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_illegal, exc_overflow, exc_underflow}));

    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(count_q));

endmodule

bind ret_guard_stack ret_guard_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .cmd_valid     (cmd_valid),
    .cmd           (cmd),
    .exc_illegal   (exc_illegal),
    .exc_overflow  (exc_overflow),
    .exc_underflow (exc_underflow),
    .count_q       (count_q),
    .held_valid_q  (held_valid_q)
);

// File: tb/ret_guard_stack_bench.sv
module ret_guard_stack_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int AW         = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd = 3'd0;
    logic [AW-1:0] data_in = '0;
    logic [AW-1:0] link_reg = '0;
    logic [AW-1:0] data_out;
    logic          exc_illegal, exc_overflow, exc_underflow;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ret_guard_stack #(.DEPTH(DEPTH), .AW(AW)) u_ret_guard_stack (
        .clk (clk), .rst_n (rst_n), .enable (enable), .cmd_valid (cmd_valid),
        .cmd (cmd), .data_in (data_in), .link_reg (link_reg),
        .data_out (data_out), .exc_illegal (exc_illegal),
        .exc_overflow (exc_overflow), .exc_underflow (exc_underflow)
    );

    task automatic expect_val(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // flags as {illegal, overflow, underflow}
    task automatic expect_exc(string req, logic [2:0] exp);
        expect_val(req, AW'({exc_illegal, exc_overflow, exc_underflow}), AW'(exp));
    endtask

    // Called at a falling edge; returns at the next falling edge with the strobe removed.
    task automatic issue(logic [2:0] c, logic [AW-1:0] d, logic [AW-1:0] l);
        cmd = c; data_in = d; link_reg = l; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        expect_val("R1 data_out", data_out, '0);
        expect_exc("R1 exceptions", 3'b000);
        issue(3'd2, '0, '0);
        expect_exc("R1 empty after reset", 3'b001);
        idle_cycle();
        expect_exc("R7 underflow one cycle", 3'b000);
        issue(3'd3, '0, '0);
        expect_exc("R1 nothing held after reset", 3'b100);
        idle_cycle();
    endtask

    task automatic t_lifo();
        for (int i = 0; i < 3; i++) begin
            issue(3'd1, 32'hA000_0000 + i, '0);
            expect_exc("R2 push no exception", 3'b000);
        end
        for (int i = 2; i >= 0; i--) begin
            issue(3'd2, '0, '0);
            expect_val("R3 pop order", data_out, 32'hA000_0000 + i);
            expect_exc("R3 pop no exception", 3'b000);
        end
    endtask

    task automatic t_check();
        issue(3'd1, 32'h1234_5678, '0);
        issue(3'd2, '0, '0);
        issue(3'd3, '0, 32'h1234_5678);
        expect_exc("R4 match no exception", 3'b000);
        issue(3'd3, '0, 32'h1234_5678);
        expect_exc("R5 second check", 3'b100);
        idle_cycle();
        expect_exc("R4 pulse one cycle", 3'b000);
        issue(3'd1, 32'h0000_BEEF, '0);
        issue(3'd2, '0, '0);
        issue(3'd3, '0, 32'h0000_BEEE);
        expect_exc("R4 mismatch", 3'b100);
        idle_cycle();
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH; i++) issue(3'd1, 32'hC000_0000 + i, '0);
        expect_exc("R6 fill no exception", 3'b000);
        issue(3'd1, 32'hDEAD_DEAD, '0);
        expect_exc("R6 overflow", 3'b010);
        for (int i = DEPTH - 1; i >= 0; i--) begin
            issue(3'd2, '0, '0);
            expect_val("R6 contents kept", data_out, 32'hC000_0000 + i);
        end
        issue(3'd2, '0, '0);
        expect_exc("R7 underflow", 3'b001);
        expect_val("R7 data_out kept", data_out, 32'hC000_0000);
        idle_cycle();
    endtask

    task automatic t_swap();
        issue(3'd4, 32'h5555_0000, '0);
        expect_exc("R8 swap empty", 3'b001);
        issue(3'd1, 32'h1111_1111, '0);
        issue(3'd4, 32'h2222_2222, '0);
        expect_val("R8 swap returns old", data_out, 32'h1111_1111);
        expect_exc("R8 swap no exception", 3'b000);
        issue(3'd2, '0, '0);
        expect_val("R8 top replaced", data_out, 32'h2222_2222);
        issue(3'd2, '0, '0);
        expect_exc("R8 depth unchanged", 3'b001);
        idle_cycle();
    endtask

    task automatic t_disabled();
        issue(3'd1, 32'h7777_0001, '0);
        enable = 1'b0;
        issue(3'd1, 32'h9999_9999, '0);
        expect_exc("R9 push ignored", 3'b000);
        issue(3'd2, '0, '0);
        expect_exc("R9 pop ignored", 3'b000);
        expect_val("R9 data_out kept", data_out, 32'h2222_2222);
        issue(3'd3, '0, 32'h0BAD_0BAD);
        expect_exc("R9 check ignored", 3'b000);
        issue(3'd4, 32'h4444_4444, '0);
        expect_val("R9 swap ignored", data_out, 32'h2222_2222);
        enable = 1'b1;
        cmd = 3'd1; data_in = 32'h3333_3333; cmd_valid = 1'b0;
        idle_cycle();
        idle_cycle();
        expect_exc("R10 no strobe", 3'b000);
        issue(3'd2, '0, '0);
        expect_val("R9 R10 stack unchanged", data_out, 32'h7777_0001);
        issue(3'd2, '0, '0);
        expect_exc("R9 R10 depth unchanged", 3'b001);
        issue(3'd6, 32'h1, '0);
        expect_exc("R2 unknown code", 3'b000);
        expect_val("R2 unknown code data", data_out, 32'h7777_0001);
        idle_cycle();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lifo();
        t_check();
        t_overflow();
        t_swap();
        t_disabled();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule